// File: doc/BRIEF.md
# MDIO Management Controller

This block is a register-driven master for the two-wire PHY management bus. It issues clause-22 read and write frames to external PHY devices. Software first sets up a control register with an enable bit, a preamble-suppress bit and an 8-bit clock divider. It then writes an access register that holds the target PHY address, the register number, a write flag, 16 data bits and a go bit. The go bit stays high while the frame is on the wire. When a read ends, the returned 16-bit value appears in the data field of the same access register.

The controller drives the MDC clock and a tri-stated MDIO data line. The line is split into an output value, an output enable and an input. The controller also keeps a 32-bit alive map with one bit per PHY address. A bit in the map is set when a PHY at that address answers a read by pulling the second turnaround bit low.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the control register reads 0x8000_0000, with bit 31 (idle) set and every other bit clear. The access register and the alive map read zero, MDC is low and `mdio_oe` is low.
- R2: A write to the access register with bit 31 set, made while bit 30 (enable) of the control register is set and no frame is running, starts a frame. From the cycle after the write until the frame ends:
  - access bit 31 (busy) reads 1;
  - control bit 31 (idle) reads 0;
  - access bits 30 (write flag), 25:21 (register) and 20:16 (PHY) keep the values written.
- R3: A frame sends these fields on MDIO, most significant bit first, changing on MDC falling edges:
  - the start pattern 01;
  - opcode 10 for a read or 01 for a write;
  - the 5-bit PHY address;
  - the 5-bit register number.
- R4: MDC is held low while no frame is running. During a frame, each MDC high phase and each MDC low phase lasts div+1 clock cycles, where div is control bits 7:0.
- R5: A write frame drives the turnaround pattern 10 and then the 16 data bits of access bits 15:0. The access data field keeps the written value after the frame.
- R6: A read frame releases MDIO (`mdio_oe` low) from the first turnaround bit to the end of the frame. The controller samples 16 data bits on MDC rising edges and places them in access bits 15:0. A line that no PHY drives, which is pulled high, reads as 0xFFFF.
- R7: Alive map bit n is set when a read to PHY address n samples the second turnaround bit low. The map changes at no other time.
- R8: When control bit 20 (preamble suppress) is clear, a frame begins with 32 one-bits. When it is set, the frame begins directly with the start pattern, so it has 32 MDC rising edges instead of 64.
- R9: A write to the access register while busy is set changes nothing: no field changes and no further frame starts.
- R10: While enable is clear, a write with bit 31 set stores the access fields but starts no frame. Busy stays 0 and MDC does not toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 access, 2 alive map |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The assertions check properties that hold on every cycle:
- busy never drops before the engine finishes;
- MDC stays low while no frame runs;
- a busy-time or disabled go write never starts or alters a frame;
- once a read has released MDIO, the line stays released;
- the alive map moves only at the end of a read.

Other behaviour needs a modelled PHY on the wire, and only the bench scenarios can show it:
- the bit-exact frame contents and opcodes;
- the preamble length, with and without suppression;
- the MDC phase length for several dividers;
- read-back of data that an earlier write placed in a PHY;
- the 0xFFFF result and unchanged alive bit for an absent PHY.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int PHY_AW     = 5;
    localparam int REG_AW     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int HDR_BITS   = 14;                       // start, opcode, phy, reg
    localparam int BODY_BITS  = HDR_BITS + 2 + DATA_W;   // header, turnaround, data
    localparam int FRAME_BITS = PRE_BITS + BODY_BITS;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int TA1_IDX    = PRE_BITS + HDR_BITS;
    localparam int TA2_IDX    = TA1_IDX + 1;
    localparam int DATA0_IDX  = TA2_IDX + 1;
    localparam int NPHY       = 1 << PHY_AW;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_ACCESS = 2'd1,
        SEL_ALIVE  = 2'd2,
        SEL_NONE   = 2'd3
    } sel_e;

    typedef struct packed {
        logic              wr;
        logic [REG_AW-1:0] rg;
        logic [PHY_AW-1:0] phy;
        logic [DATA_W-1:0] data;
    } acc_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        wrap = (st_q.cnt >= div_i);
        st_d = st_q;
        if (!run_i) begin
            st_d.cnt = '0;
            st_d.mdc = 1'b0;
        end else if (wrap) begin
            st_d.cnt = '0;
            st_d.mdc = ~st_q.mdc;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o  = st_q.mdc;
    assign rise_o = run_i && wrap && !st_q.mdc;
    assign fall_o = run_i && wrap &&  st_q.mdc;
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  acc_t              cmd_i,
    input  logic              nopre_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mdio_i,
    output logic              active_o,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              ta_ok_o
);
    typedef struct packed {
        logic                  active;
        logic                  wr;
        logic [BIT_W-1:0]      bitn;
        logic [FRAME_BITS-1:0] frm;
        logic [DATA_W-1:0]     cap;
        logic                  ta_ok;
    } eng_st_t;

    eng_st_t                st_d, st_q;
    logic [BODY_BITS-1:0]   body;
    logic                   last;

    always_comb begin
        body = {2'b01,
                cmd_i.wr ? 2'b01 : 2'b10,
                cmd_i.phy,
                cmd_i.rg,
                cmd_i.wr ? 2'b10 : 2'b11,
                cmd_i.wr ? cmd_i.data : {DATA_W{1'b1}}};
        last = (st_q.bitn == BIT_W'(FRAME_BITS - 1));
        st_d = st_q;
        if (start_i && !st_q.active) begin
            st_d.active = 1'b1;
            st_d.wr     = cmd_i.wr;
            st_d.bitn   = nopre_i ? BIT_W'(PRE_BITS) : '0;
            st_d.frm    = nopre_i ? {body, {PRE_BITS{1'b0}}}
                                  : {{PRE_BITS{1'b1}}, body};
            st_d.cap    = '0;
            st_d.ta_ok  = 1'b0;
        end else if (st_q.active) begin
            if (rise_i && !st_q.wr) begin
                if (st_q.bitn == BIT_W'(TA2_IDX))
                    st_d.ta_ok = !mdio_i;
                if (st_q.bitn >= BIT_W'(DATA0_IDX))
                    st_d.cap = {st_q.cap[DATA_W-2:0], mdio_i};
            end
            if (fall_i) begin
                if (last) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.bitn = st_q.bitn + 1'b1;
                    st_d.frm  = st_q.frm << 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o  = st_q.active;
    assign mdio_o    = st_q.active & st_q.frm[FRAME_BITS-1];
    assign mdio_oe_o = st_q.active && (st_q.wr || st_q.bitn < BIT_W'(TA1_IDX));
    assign done_o    = st_q.active && fall_i && last;
    assign rdata_o   = st_q.cap;
    assign ta_ok_o   = st_q.ta_ok;

    // R6: once a read has let go of the line it stays released until the frame ends
    assert_rd_release_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !st_q.wr && !mdio_oe_o) |=> (!st_q.active || !mdio_oe_o));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic             en;
        logic             nopre;
        logic [DIV_W-1:0] div;
        logic             busy;
        acc_t             acc;
        logic [NPHY-1:0]  alive;
    } top_st_t;

    top_st_t           st_d, st_q;
    sel_e              sel;
    logic              start;
    logic              eng_active, eng_done, eng_ta_ok;
    logic              tick_rise, tick_fall;
    logic [DATA_W-1:0] eng_rdata;

    always_comb begin
        sel   = sel_e'(cfg_addr);
        start = 1'b0;
        st_d  = st_q;
        if (cfg_we && sel == SEL_CTRL) begin
            st_d.en    = cfg_wdata[30];
            st_d.nopre = cfg_wdata[20];
            st_d.div   = cfg_wdata[DIV_W-1:0];
        end
        if (cfg_we && sel == SEL_ACCESS && !st_q.busy) begin
            st_d.acc.wr   = cfg_wdata[30];
            st_d.acc.rg   = cfg_wdata[25:21];
            st_d.acc.phy  = cfg_wdata[20:16];
            st_d.acc.data = cfg_wdata[15:0];
            if (cfg_wdata[31] && st_q.en) begin
                st_d.busy = 1'b1;
                start     = 1'b1;
            end
        end
        if (eng_done) begin
            st_d.busy = 1'b0;
            if (!st_q.acc.wr) begin
                st_d.acc.data = eng_rdata;
                if (eng_ta_ok) st_d.alive[st_q.acc.phy] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL:   cfg_rdata = {~st_q.busy, st_q.en, 9'b0, st_q.nopre, 12'b0, 8'(st_q.div)};
            SEL_ACCESS: cfg_rdata = {st_q.busy, st_q.acc.wr, 4'b0, st_q.acc.rg, st_q.acc.phy, st_q.acc.data};
            SEL_ALIVE:  cfg_rdata = 32'(st_q.alive);
            default:    cfg_rdata = '0;
        endcase
    end

    mdio_clk_div #(.DIV_W(DIV_W)) clk_div_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (eng_active),
        .div_i  (st_q.div),
        .mdc_o  (mdc),
        .rise_o (tick_rise),
        .fall_o (tick_fall)
    );

    mdio_frame_engine engine_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .cmd_i     (st_d.acc),
        .nopre_i   (st_q.nopre),
        .rise_i    (tick_rise),
        .fall_i    (tick_fall),
        .mdio_i    (mdio_i),
        .active_o  (eng_active),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe),
        .done_o    (eng_done),
        .rdata_o   (eng_rdata),
        .ta_ok_o   (eng_ta_ok)
    );

    // R2: busy holds until the engine reports the end of the frame
    assert_busy_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !eng_done) |=> st_q.busy);

    // R4: no clock activity while idle
    assert_mdc_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> !mdc);

    // R9: an access write during a frame leaves the command untouched
    assert_ignore_busy_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !eng_done && cfg_we && sel == SEL_ACCESS)
        |=> ($stable(st_q.acc) && st_q.busy));

    // R10: a disabled controller never starts a frame
    assert_no_start_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.en |=> !$rose(st_q.busy));

    // R7: the alive map moves only when a read finishes
    assert_alive_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(eng_done && !st_q.acc.wr) |=> $stable(st_q.alive));
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [31:0] cfg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        phy_o, phy_oe;
    wire         mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    always #2 clk = ~clk;   // 250 MHz

    mdio_mgmt_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .mdc       (mdc),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .mdio_i    (mdio_line)
    );

    typedef struct packed {
        logic        wr;
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic [15:0] wdat;
        logic        nopre;
        logic [7:0]  div;
        logic [15:0] exp;
        logic        answers;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 5'd5,  5'd2,  16'h0000, 1'b0, 8'd1, 16'hA513, 1'b1},
        '{1'b1, 5'd5,  5'd9,  16'h1234, 1'b0, 8'd0, 16'h1234, 1'b0},
        '{1'b0, 5'd17, 5'd31, 16'h0000, 1'b1, 8'd3, 16'hB1FB, 1'b1},
        '{1'b0, 5'd9,  5'd0,  16'h0000, 1'b0, 8'd2, 16'hFFFF, 1'b0},
        '{1'b1, 5'd17, 5'd0,  16'hBEEF, 1'b1, 8'd0, 16'hBEEF, 1'b0},
        '{1'b0, 5'd17, 5'd0,  16'h0000, 1'b0, 8'd1, 16'hBEEF, 1'b1},
        '{1'b0, 5'd5,  5'd9,  16'h0000, 1'b1, 8'd0, 16'h1234, 1'b1}
    };

    int unsigned n_cmp = 0, n_bad = 0;
    bit          finished = 1'b0;

    // ---------------- PHY model ----------------
    logic [15:0] mem [2][32];
    int          pos;
    logic [13:0] hdr;
    logic [15:0] wsh, last_wdata;
    logic [1:0]  cur_op;
    logic [4:0]  cur_phy, cur_reg;
    logic        ln;
    int unsigned frame_cnt = 0, wr_cnt = 0, proto_err = 0, pre_run = 0, last_pre = 0;
    int          nxt;

    function automatic bit present(input logic [4:0] p);
        return (p == 5'd5) || (p == 5'd17);
    endfunction
    function automatic int pidx(input logic [4:0] p);
        return (p == 5'd5) ? 0 : 1;
    endfunction

    initial begin
        for (int r = 0; r < 32; r++) begin
            mem[0][r] = {3'b101, 5'd5,  5'(r), 3'b011};
            mem[1][r] = {3'b101, 5'd17, 5'(r), 3'b011};
        end
        pos = -1; phy_oe = 1'b0; phy_o = 1'b1;
        cur_op = 2'b00; cur_phy = '0; cur_reg = '0; hdr = '0; wsh = '0; last_wdata = '0;
        forever begin
            @(mdc);
            if (mdc === 1'b1) begin
                ln = mdio_line;
                if (pos < 0) begin
                    if (ln == 1'b0) begin
                        pos = 0; hdr = '0; last_pre = pre_run; pre_run = 0;
                    end else pre_run++;
                end else pos++;
                if (pos >= 0 && pos <= 13) hdr = {hdr[12:0], ln};
                if (pos == 13) begin
                    frame_cnt++;
                    if (hdr[13:12] != 2'b01) proto_err++;
                    cur_op = hdr[11:10]; cur_phy = hdr[9:5]; cur_reg = hdr[4:0];
                end
                if (pos == 14 && cur_op == 2'b01 && ln != 1'b1) proto_err++;
                if (pos == 15 && cur_op == 2'b01 && ln != 1'b0) proto_err++;
                if (pos >= 16) wsh = {wsh[14:0], ln};
                if (pos == 31) begin
                    if (cur_op == 2'b01) begin
                        wr_cnt++; last_wdata = wsh;
                        if (present(cur_phy)) mem[pidx(cur_phy)][cur_reg] = wsh;
                    end
                    pos = -1;
                end
            end else if (mdc === 1'b0) begin
                if (pos >= 13 && pos < 31 && cur_op == 2'b10 && present(cur_phy)) begin
                    nxt = pos + 1;
                    if (nxt == 15) begin phy_oe = 1'b1; phy_o = 1'b0; end
                    else if (nxt >= 16) begin phy_oe = 1'b1; phy_o = mem[pidx(cur_phy)][cur_reg][31-nxt]; end
                end else phy_oe = 1'b0;
            end
        end
    end

    // ---------------- monitors ----------------
    int unsigned cyc = 0, rise_total = 0, t_rise = 0, hi_len = 0;
    int unsigned hi_min = 0, hi_max = 0, epoch = 0, seen_epoch = 0, contention = 0;

    initial forever begin
        @(negedge clk);
        cyc++;
        if (mdio_oe === 1'b1 && phy_oe === 1'b1) contention++;
    end

    initial forever begin
        @(posedge mdc);
        t_rise = cyc; rise_total++;
        @(negedge mdc);
        hi_len = cyc - t_rise;
        if (epoch != seen_epoch) begin hi_min = hi_len; hi_max = hi_len; seen_epoch = epoch; end
        else begin
            if (hi_len < hi_min) hi_min = hi_len;
            if (hi_len > hi_max) hi_max = hi_len;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int g = 0; g < 20000; g++) begin
            cfg_read(2'd1, r);
            if (!r[31]) return;
            @(negedge clk);
        end
        chk("R2", "frame never finished", 32'd1, 32'd0);
    endtask

    logic [31:0] exp_alive = '0;

    task automatic run_vec(input vec_t v);
        logic [31:0] r;
        int unsigned r0, f0, w0;
        epoch++;
        cfg_write(2'd0, {1'b0, 1'b1, 9'b0, v.nopre, 12'b0, v.div});
        cfg_read(2'd0, r);
        chk("R8", "control readback", r, {1'b1, 1'b1, 9'b0, v.nopre, 12'b0, v.div});
        r0 = rise_total; f0 = frame_cnt; w0 = wr_cnt;
        cfg_write(2'd1, {1'b1, v.wr, 4'b0, v.rg, v.phy, v.wdat});
        cfg_read(2'd1, r);
        chk("R2", "busy after go", 32'(r[31]), 32'd1);
        cfg_read(2'd0, r);
        chk("R2", "idle low while busy", 32'(r[31]), 32'd0);
        wait_idle();
        cfg_read(2'd1, r);
        chk("R2", "fields kept", 32'(r[30:16]), 32'({v.wr, 4'b0, v.rg, v.phy}));
        chk(v.wr ? "R5" : "R6", "data field", 32'(r[15:0]), 32'(v.exp));
        if (v.answers) exp_alive[v.phy] = 1'b1;
        cfg_read(2'd2, r);
        chk("R7", "alive map", r, exp_alive);
        chk("R3", "frame count", frame_cnt - f0, 32'd1);
        chk("R3", "opcode", 32'(cur_op), v.wr ? 32'd1 : 32'd2);
        chk("R3", "phy field", 32'(cur_phy), 32'(v.phy));
        chk("R3", "reg field", 32'(cur_reg), 32'(v.rg));
        chk("R8", "preamble ones", last_pre, v.nopre ? 32'd0 : 32'd32);
        chk("R8", "mdc rises", rise_total - r0, v.nopre ? 32'd32 : 32'd64);
        chk("R4", "mdc high min", hi_min, 32'(v.div) + 32'd1);
        chk("R4", "mdc high max", hi_max, 32'(v.div) + 32'd1);
        if (v.wr) begin
            chk("R5", "phy write count", wr_cnt - w0, 32'd1);
            chk("R5", "phy write data", 32'(last_wdata), 32'(v.wdat));
        end
        chk("R6", "no line contention", contention, 32'd0);
        chk("R5", "frame protocol", proto_err, 32'd0);
    endtask

    // ---------------- main ----------------
    initial begin
        logic [31:0] r;
        int unsigned r0, f0, w0;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        cfg_read(2'd0, r); chk("R1", "control reset", r, 32'h8000_0000);
        cfg_read(2'd1, r); chk("R1", "access reset", r, 32'h0);
        cfg_read(2'd2, r); chk("R1", "alive reset", r, 32'h0);
        chk("R1", "mdc reset", 32'(mdc), 32'd0);
        chk("R1", "oe reset", 32'(mdio_oe), 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: access write during a running frame
        cfg_write(2'd0, {1'b0, 1'b1, 30'd0});
        f0 = frame_cnt; w0 = wr_cnt;
        cfg_write(2'd1, {1'b1, 1'b0, 4'b0, 5'd2, 5'd5, 16'h0000});
        repeat (3) @(negedge clk);
        cfg_write(2'd1, {1'b1, 1'b1, 4'b0, 5'd3, 5'd17, 16'h0F0F});
        wait_idle();
        cfg_read(2'd1, r);
        chk("R9", "access after ignored write", r, {1'b0, 1'b0, 4'b0, 5'd2, 5'd5, 16'hA513});
        repeat (300) @(negedge clk);
        cfg_read(2'd1, r);
        chk("R9", "no second frame busy", 32'(r[31]), 32'd0);
        chk("R9", "frames seen", frame_cnt - f0, 32'd1);
        chk("R9", "no write frame", wr_cnt - w0, 32'd0);

        // R10: go while disabled
        cfg_write(2'd0, 32'h0000_0002);
        r0 = rise_total; f0 = frame_cnt;
        cfg_write(2'd1, {1'b1, 1'b0, 4'b0, 5'd4, 5'd5, 16'h0000});
        cfg_read(2'd1, r);
        chk("R10", "busy stays low", 32'(r[31]), 32'd0);
        chk("R10", "fields stored", 32'(r[25:16]), 32'({5'd4, 5'd5}));
        repeat (200) @(negedge clk);
        chk("R10", "no mdc edges", rise_total - r0, 32'd0);
        chk("R10", "no frame", frame_cnt - f0, 32'd0);
        chk("R10", "mdc low", 32'(mdc), 32'd0);
        cfg_read(2'd0, r);
        chk("R10", "control idle", r, 32'h8000_0002);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule